// File: doc/BRIEF.md
# Oversampled Serial Receiver with Sticky Error Flags

This block is the receive half of an asynchronous serial port. A free-running tick at sixteen times the bit rate paces it. It finds the falling edge of a start bit and confirms it in the middle of that bit. It then samples each data bit, the optional parity bit and one or two stop bits at their centres. Each finished character goes into a small receive queue that software drains through a byte-wide read port.

Line problems are recorded in sticky flags: a parity mismatch, a missing stop bit, a character lost to a full queue, and a break (a missing stop bit together with an all-zero character). None of these flags clears on its own. A level-sensitive clear input holds all of them at zero for as long as it stays high. A programmable fill threshold raises the receive interrupt. The baud tick source and the register bus sit outside this block.

Top module: `serial_rx_unit`

## Requirements
- R1: Each bit lasts 16 `os_tick` pulses. A low level must still be present 8 ticks after it is first seen, or it is dropped as a glitch. Data bits arrive least significant first. While `rx_en` is low the receiver stays idle and takes in no character.
- R2: `cfg_len` selects the character length: 0 gives 8 bits, 1 gives 7, 2 gives 6 and 3 gives 5. Bits above the configured length read back as zero.
- R3: With `cfg_par_en` high, a parity bit follows the data. With `cfg_par_odd` low, the data plus parity must hold an even number of ones; with it high, an odd number. A mismatch sets `par_err`.
- R4: With `cfg_two_stop` high, two stop bits are checked instead of one. A low level at the centre of any stop bit sets `frm_err`.
- R5: A character with a framing error and data 0x00 also sets `brk_err`. After a low stop bit, the receiver waits for the line to return high before it looks for a new start bit, so a long break yields exactly one queue entry.
- R6: `par_err`, `frm_err`, `ovr_err` and `brk_err` stay set until `err_clr` is raised. While `err_clr` is high they read zero and new events are not recorded. Recording resumes once `err_clr` is low.
- R7: `rd_data` shows the oldest queued byte, or 0 when the queue is empty. A `rd_pop` pulse removes that byte. `rx_empty` is high when the queue is empty. A pop on an empty queue has no effect.
- R8: A character that completes while the queue is full is discarded and sets `ovr_err`. The queued bytes and their order are unchanged.
- R9: While `rx_flush` is high, the queue is empty and completed characters are discarded.
- R10: `irq` is high exactly when `irq_en` is high and the queue holds at least `irq_level` entries. A level of 0 therefore asserts `irq` whenever it is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversampling strobe, 16 per bit |
| rxd | input | 1 | Serial line, idles high |
| rx_en | input | 1 | Receiver enable |
| rx_flush | input | 1 | Hold high to empty the queue |
| err_clr | input | 1 | Level-sensitive clear for all error flags |
| cfg_len | input | 2 | Character length code (R2) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | Odd parity when high |
| cfg_two_stop | input | 1 | Two stop bits when high |
| irq_en | input | 1 | Receive interrupt enable |
| irq_level | input | 8 | Queue fill threshold for `irq` |
| rd_pop | input | 1 | Remove the head byte |
| rd_data | output | 8 | Head byte of the queue |
| rx_empty | output | 1 | Queue empty |
| par_err | output | 1 | Sticky parity error |
| frm_err | output | 1 | Sticky framing error |
| ovr_err | output | 1 | Sticky overrun |
| brk_err | output | 1 | Sticky break |
| irq | output | 1 | Receive interrupt |

## Verification
A sampling phase that drifts by even one tick does not always fail at once. It tends to show up on the next character with a long run of equal bits, as a wrong `rd_data` value or a spurious `par_err` or `frm_err`. A receiver stuck after a break shows up as a second, phantom zero byte, or as a missing next character, within one character time after the line goes high again. A wrong fill count shows up directly at `irq` and `rx_empty` on the cycle after the push or pop, and as lost or duplicated bytes when the queue is drained.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_HOLD
  } srx_state_e;

  typedef struct packed {
    logic [7:0] data;
    logic       perr;
    logic       ferr;
  } srx_frame_t;

  // number of data bits for a length code
  function automatic logic [3:0] word_bits(input logic [1:0] len);
    return 4'd8 - {2'b00, len};
  endfunction

  // parity bit a correct transmitter would send
  function automatic logic parity_of(input logic [7:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

endpackage

// File: rtl/srx_frame_sampler.sv
module srx_frame_sampler
  import srx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  input  logic       enable,
  input  logic [1:0] len,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       two_stop,
  output logic       frame_valid,
  output srx_frame_t frame_q
);
  localparam int PW = $clog2(OSR);
  localparam logic [PW-1:0] MID  = PW'(OSR / 2 - 1);
  localparam logic [PW-1:0] LAST = PW'(OSR - 1);

  logic [1:0]  sync_q;
  logic        rx_s;
  srx_state_e  state;
  logic [PW-1:0] ph;
  logic [2:0]  idx;
  logic        stop_n;
  logic [7:0]  shreg;
  logic        perr, ferr;
  logic        ferr_now;

  assign rx_s     = sync_q[1];
  assign ferr_now = ferr | ~rx_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rxd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      ph          <= '0;
      idx         <= '0;
      stop_n      <= 1'b0;
      shreg       <= '0;
      perr        <= 1'b0;
      ferr        <= 1'b0;
      frame_valid <= 1'b0;
      frame_q     <= '0;
    end else begin
      frame_valid <= 1'b0;
      if (!enable) begin
        state <= ST_IDLE;
      end else if (tick) begin
        unique case (state)
          ST_IDLE: if (!rx_s) begin
            state <= ST_START;
            ph    <= '0;
          end
          ST_START: if (ph == MID) begin
            ph <= '0;
            if (!rx_s) begin
              state <= ST_DATA;
              idx   <= '0;
              shreg <= '0;
              perr  <= 1'b0;
              ferr  <= 1'b0;
            end else begin
              state <= ST_IDLE;
            end
          end else ph <= ph + 1'b1;
          ST_DATA: if (ph == LAST) begin
            ph         <= '0;
            shreg[idx] <= rx_s;
            idx        <= idx + 1'b1;
            if ({1'b0, idx} == word_bits(len) - 4'd1) begin
              state  <= par_en ? ST_PAR : ST_STOP;
              stop_n <= 1'b0;
            end
          end else ph <= ph + 1'b1;
          ST_PAR: if (ph == LAST) begin
            ph     <= '0;
            perr   <= (rx_s != parity_of(shreg, par_odd));
            state  <= ST_STOP;
            stop_n <= 1'b0;
          end else ph <= ph + 1'b1;
          ST_STOP: if (ph == LAST) begin
            ph <= '0;
            if (two_stop && !stop_n) begin
              stop_n <= 1'b1;
              ferr   <= ferr_now;
            end else begin
              frame_valid <= 1'b1;
              frame_q     <= '{data: shreg, perr: perr, ferr: ferr_now};
              state       <= (!rx_s) ? ST_HOLD : ST_IDLE;
            end
          end else ph <= ph + 1'b1;
          ST_HOLD: if (rx_s) state <= ST_IDLE;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo #(
  parameter int DEPTH = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [7:0]    push_data,
  input  logic          pop,
  output logic [7:0]    head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push & ~flush & ~full;
  assign do_pop  = pop & ~flush & ~empty;
  assign head    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else if (flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/srx_sticky_flags.sv
module srx_sticky_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [N-1:0] set,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flags[i] <= 1'b0;
      else if (clr) flags[i] <= 1'b0;
      else if (set[i]) flags[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/serial_rx_unit.sv
module serial_rx_unit
  import srx_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic       rxd,
  input  logic       rx_en,
  input  logic       rx_flush,
  input  logic       err_clr,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       cfg_two_stop,
  input  logic       irq_en,
  input  logic [7:0] irq_level,
  input  logic       rd_pop,
  output logic [7:0] rd_data,
  output logic       rx_empty,
  output logic       par_err,
  output logic       frm_err,
  output logic       ovr_err,
  output logic       brk_err,
  output logic       irq
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int NFLAG = 4;

  logic             frame_valid;
  srx_frame_t       frame;
  logic [7:0]       fifo_head;
  logic [CW-1:0]    fifo_count;
  logic             fifo_full, fifo_empty;
  logic             drop_evt, break_evt;
  logic [NFLAG-1:0] flag_set, flag_q;

  srx_frame_sampler #(.OSR(OSR)) u_sampler (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .rxd(rxd), .enable(rx_en),
    .len(cfg_len), .par_en(cfg_par_en), .par_odd(cfg_par_odd),
    .two_stop(cfg_two_stop), .frame_valid(frame_valid), .frame_q(frame)
  );

  srx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush), .push(frame_valid),
    .push_data(frame.data), .pop(rd_pop), .head(fifo_head),
    .count(fifo_count), .full(fifo_full), .empty(fifo_empty)
  );

  assign drop_evt  = frame_valid & fifo_full & ~rx_flush;
  assign break_evt = frame_valid & frame.ferr & (frame.data == 8'h00);
  assign flag_set  = {break_evt, drop_evt,
                      frame_valid & frame.ferr, frame_valid & frame.perr};

  srx_sticky_flags #(.N(NFLAG)) u_flags (
    .clk(clk), .rst_n(rst_n), .clr(err_clr), .set(flag_set), .flags(flag_q)
  );

  assign par_err  = flag_q[0];
  assign frm_err  = flag_q[1];
  assign ovr_err  = flag_q[2];
  assign brk_err  = flag_q[3];
  assign rx_empty = fifo_empty;
  assign rd_data  = fifo_empty ? 8'h00 : fifo_head;
  assign irq      = irq_en & (32'(fifo_count) >= 32'(irq_level));
endmodule

// File: rtl/serial_rx_unit_chk.sv
module serial_rx_unit_chk (
  input logic clk,
  input logic rst_n,
  input logic err_clr,
  input logic rx_flush,
  input logic irq_en,
  input logic irq,
  input logic rd_pop,
  input logic rx_empty,
  input logic par_err,
  input logic frm_err,
  input logic ovr_err,
  input logic brk_err,
  input logic frame_valid,
  input logic fifo_full
);
  AST_CLEAR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr |=> !(par_err || frm_err || ovr_err || brk_err)); // R6
  AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err && !err_clr) |=> par_err); // R6
  AST_BREAK_FRAMED: assert property (@(posedge clk) disable iff (!rst_n)
    brk_err |-> frm_err); // R5
  AST_POP_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_empty && !frame_valid) |=> rx_empty); // R7
  AST_FULL_NO_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && !rd_pop && !rx_flush) |=> fifo_full); // R8
  AST_OVR_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && fifo_full && !rx_flush && !err_clr) |=> ovr_err); // R8
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> rx_empty); // R9
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq); // R10
endmodule

bind serial_rx_unit serial_rx_unit_chk chk_i (
  .clk(clk), .rst_n(rst_n), .err_clr(err_clr), .rx_flush(rx_flush),
  .irq_en(irq_en), .irq(irq), .rd_pop(rd_pop), .rx_empty(rx_empty),
  .par_err(par_err), .frm_err(frm_err), .ovr_err(ovr_err),
  .brk_err(brk_err), .frame_valid(frame_valid), .fifo_full(fifo_full)
);

// File: tb/serial_rx_unit_tb_top.sv
`timescale 1ns/1ps
module serial_rx_unit_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic os_tick = 1'b1, rxd = 1'b1, rx_en = 1'b1, rx_flush = 1'b0, err_clr = 1'b0;
  logic [1:0] cfg_len = 2'd0;
  logic cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_two_stop = 1'b0;
  logic irq_en = 1'b0, rd_pop = 1'b0;
  logic [7:0] irq_level = 8'd1;
  logic [7:0] rd_data;
  logic rx_empty, par_err, frm_err, ovr_err, brk_err, irq;
  int checks = 0, errors = 0, cyc = 0;

  always #10 clk = ~clk;

  serial_rx_unit dut_i (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd), .rx_en(rx_en),
    .rx_flush(rx_flush), .err_clr(err_clr), .cfg_len(cfg_len),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_two_stop(cfg_two_stop), .irq_en(irq_en), .irq_level(irq_level),
    .rd_pop(rd_pop), .rd_data(rd_data), .rx_empty(rx_empty),
    .par_err(par_err), .frm_err(frm_err), .ovr_err(ovr_err),
    .brk_err(brk_err), .irq(irq)
  );

  typedef struct packed {
    logic [1:0] len; logic pe, po, ts, bp, bs;
    logic [7:0] d; logic [7:0] xd; logic xp, xf;
  } vec_t;
  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 8'hA5, 1'b0, 1'b0},
    '{2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'hD3, 8'h53, 1'b0, 1'b0},
    '{2'd3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'hFF, 8'h1F, 1'b0, 1'b0},
    '{2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h2A, 8'h2A, 1'b1, 1'b0},
    '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h3C, 8'h3C, 1'b0, 1'b1},
    '{2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0}
  };

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      errors++;
      $display("FAIL watchdog R1 act=%0d exp<%0d", cyc, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic bit_time(input logic v);
    rxd = v;
    repeat (16) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic bad_par, input logic bad_stop);
    int n;
    logic p;
    n = 8 - int'(cfg_len);
    p = (^(d & (8'hFF >> cfg_len))) ^ cfg_par_odd ^ bad_par;
    @(negedge clk);
    bit_time(1'b0);
    for (int i = 0; i < n; i++) bit_time(d[i]);
    if (cfg_par_en) bit_time(p);
    bit_time(~bad_stop);
    if (cfg_two_stop) bit_time(1'b1);
    bit_time(1'b1);
    bit_time(1'b1);
  endtask

  task automatic pop1();
    @(negedge clk) rd_pop = 1'b1;
    @(negedge clk) rd_pop = 1'b0;
  endtask

  task automatic clear1();
    @(negedge clk) err_clr = 1'b1;
    @(negedge clk) err_clr = 1'b0;
  endtask

  task automatic plain();
    cfg_len = 2'd0; cfg_par_en = 1'b0; cfg_par_odd = 1'b0; cfg_two_stop = 1'b0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R7 reset empty", rx_empty, 1);
    chk("R7 reset data", rd_data, 8'h00);
    chk("R6 reset flags", {par_err, frm_err, ovr_err, brk_err}, 4'h0);
    chk("R10 reset irq", irq, 0);

    // vector table: lengths R2, parity R3, stop bits R4
    for (int k = 0; k < NV; k++) begin
      clear1();
      cfg_len = VECS[k].len; cfg_par_en = VECS[k].pe;
      cfg_par_odd = VECS[k].po; cfg_two_stop = VECS[k].ts;
      send(VECS[k].d, VECS[k].bp, VECS[k].bs);
      chk("R1 R2 data", rd_data, VECS[k].xd);
      chk("R3 parity flag", par_err, VECS[k].xp);
      chk("R4 framing flag", frm_err, VECS[k].xf);
      chk("R5 break flag", brk_err, 0);
      chk("R7 not empty", rx_empty, 0);
      pop1();
      chk("R7 empty after pop", rx_empty, 1);
    end

    // R6: flags held clear while err_clr high
    plain(); cfg_par_en = 1'b1;
    clear1();
    @(negedge clk) err_clr = 1'b1;
    send(8'h11, 1'b1, 1'b0);
    chk("R6 held clear", par_err, 0);
    chk("R6 byte still queued", rd_data, 8'h11);
    @(negedge clk) err_clr = 1'b0;
    @(negedge clk);
    chk("R6 stays clear after release", par_err, 0);
    pop1();
    send(8'h12, 1'b1, 1'b0);
    chk("R6 latches again", par_err, 1);
    pop1();
    clear1();
    plain();

    // R5: long break gives one zero entry with framing and break flags
    @(negedge clk) rxd = 1'b0;
    repeat (16 * 14) @(negedge clk);
    rxd = 1'b1;
    repeat (64) @(negedge clk);
    chk("R5 break data", rd_data, 8'h00);
    chk("R5 break framing", frm_err, 1);
    chk("R5 break flag", brk_err, 1);
    pop1();
    chk("R5 single entry", rx_empty, 1);
    clear1();

    // R1: short glitch rejected
    @(negedge clk) rxd = 1'b0;
    repeat (4) @(negedge clk);
    rxd = 1'b1;
    repeat (300) @(negedge clk);
    chk("R1 glitch ignored", rx_empty, 1);

    // R1: disabled receiver
    rx_en = 1'b0;
    send(8'h5A, 1'b0, 1'b0);
    chk("R1 disabled no byte", rx_empty, 1);
    rx_en = 1'b1;

    // R7: pop on empty ignored
    pop1();
    send(8'h5A, 1'b0, 1'b0);
    chk("R7 data after empty pop", rd_data, 8'h5A);
    pop1();
    chk("R7 single entry", rx_empty, 1);

    // R10 threshold, R8 overrun, R7 order
    irq_level = 8'd3; irq_en = 1'b1;
    send(8'h01, 1'b0, 1'b0);
    chk("R10 below level 1", irq, 0);
    send(8'h02, 1'b0, 1'b0);
    chk("R10 below level 2", irq, 0);
    send(8'h03, 1'b0, 1'b0);
    chk("R10 at level", irq, 1);
    @(negedge clk) irq_en = 1'b0;
    @(negedge clk);
    chk("R10 disabled", irq, 0);
    irq_en = 1'b1;
    send(8'h04, 1'b0, 1'b0);
    chk("R8 no overrun when just full", ovr_err, 0);
    send(8'h05, 1'b0, 1'b0);
    chk("R8 overrun set", ovr_err, 1);
    for (int j = 1; j <= 4; j++) begin
      chk("R8 R7 order kept", rd_data, 32'(j));
      pop1();
    end
    chk("R8 dropped byte absent", rx_empty, 1);
    chk("R10 empty above zero level", irq, 0);
    @(negedge clk) irq_level = 8'd0;
    @(negedge clk);
    chk("R10 zero level", irq, 1);
    irq_en = 1'b0; irq_level = 8'd1;
    clear1();

    // R9: flush
    send(8'h66, 1'b0, 1'b0);
    send(8'h77, 1'b0, 1'b0);
    @(negedge clk) rx_flush = 1'b1;
    @(negedge clk);
    chk("R9 flushed", rx_empty, 1);
    send(8'h88, 1'b0, 1'b0);
    chk("R9 discard during flush", rx_empty, 1);
    @(negedge clk) rx_flush = 1'b0;
    @(negedge clk);
    chk("R9 empty after release", rx_empty, 1);
    send(8'h99, 1'b0, 1'b0);
    chk("R9 receive resumes", rd_data, 8'h99);
    pop1();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule